// File: doc/BRIEF.md
# Receive FIFO and Interrupt Status Controller

This block sits next to an I2C master engine and owns the byte FIFO that carries data between the bus engine and software, along with the interrupt status logic that tells software when to service it. The engine pushes and pops bytes with single-cycle strobes and signals transfer events (bus error, lost arbitration, data done, target address acknowledged, address refused) with one-cycle pulses. The block turns those pulses and the FIFO fill level into sticky status bits. An enable mask then gates the status bits onto a single interrupt line.

Software reaches four word registers through a plain read/write port with a combinational read. These are the FIFO control word (high and low thresholds plus a self-clearing FIFO reset), the fill level, the enable mask and the status word. Status bits are cleared by writing ones. Each time it services the FIFO, software rewrites the high threshold: to 1 when only a length byte is expected, otherwise to the remaining byte count capped at the FIFO depth.

Top module: `fifo_irq_ctrl`

## Requirements
- R1: After reset the fill level, status word, enable mask and both thresholds read as zero, and `irq` and `xfer_err` are low.
- R2: Bytes leave the FIFO in the order they were pushed. Register 1 reports the fill level in bits 7:0, one cycle after each accepted push or pop.
- R3: The FIFO holds 128 bytes. A push while full and a pop while empty are ignored and leave the level and contents unchanged. Status bit 4 sets while the level is 128.
- R4: Register 0 holds the high threshold in bits 15:8 and the low threshold in bits 7:0. Status bit 2 sets in the cycle after the level is at least a non-zero high threshold, and never sets while the threshold is zero.
- R5: Status bit 3 sets whenever the level is 0, but only once at least one pop has been accepted since reset.
- R6: Event pulses set status bits on the next clock edge: bus error bit 0, arbitration lost bit 11, data done bit 12, address acknowledged bit 13, address refused bit 25.
- R7: Every status bit is sticky. It stays set after its condition goes away, until software clears it.
- R8: A write to register 3 clears exactly the status bits that are one in the written value. A bit whose condition is true in the same cycle stays set, because the set takes priority over the clear.
- R9: `irq` is high exactly when some status bit and the same bit of the enable mask (register 2) are both set. Writing 0 to the enable mask drops `irq` on the next cycle.
- R10: Writing register 0 with bit 16 set empties the FIFO, clears its pointers and loads the thresholds from the same write. The status word is left as it was, and bit 16 reads back as 0.
- R11: `xfer_err` is high while any of status bits 0, 11 or 25 is set, whatever the enable mask holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register index: 0 control, 1 level, 2 enable, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| fifo_push | input | 1 | Push strobe from the bus engine |
| push_byte | input | 8 | Byte to push |
| fifo_pop | input | 1 | Pop strobe |
| pop_byte | output | 8 | Byte at the FIFO head |
| ev_bus_err | input | 1 | Bus error pulse |
| ev_arb_lost | input | 1 | Arbitration lost pulse |
| ev_done | input | 1 | Data done pulse |
| ev_addr_ack | input | 1 | Target address acknowledged pulse |
| ev_addr_nack | input | 1 | Address refused pulse |
| irq | output | 1 | Interrupt line |
| xfer_err | output | 1 | Transfer-ending error present in status |

## Verification
A status clear and the condition that sets the same bit can fall in the same cycle. The sharpest case is the empty bit: the FIFO has been drained and stays empty while software writes a one to clear bit 3. The bench drains the FIFO, writes the clear, and then reads the status word. A correct design shows bit 3 still set, because the level condition re-asserts on the very edge of the clear. Sticky bits with no active condition are cleared by the same kind of write, which confirms that the write itself takes effect.

// File: rtl/fifo_irq_ctrl.sv
`timescale 1ns/1ps
module fifo_irq_ctrl #(
  parameter int DEPTH = 128,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [1:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  input  logic          fifo_push,
  input  logic [DW-1:0] push_byte,
  input  logic          fifo_pop,
  output logic [DW-1:0] pop_byte,
  input  logic          ev_bus_err,
  input  logic          ev_arb_lost,
  input  logic          ev_done,
  input  logic          ev_addr_ack,
  input  logic          ev_addr_nack,
  output logic          irq,
  output logic          xfer_err
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_LVL  = 2'd1;
  localparam logic [1:0] A_EN   = 2'd2;
  localparam logic [1:0] A_STAT = 2'd3;

  localparam int B_BUSERR = 0;
  localparam int B_HI     = 2;
  localparam int B_EMPTY  = 3;
  localparam int B_FULL   = 4;
  localparam int B_ARB    = 11;
  localparam int B_DONE   = 12;
  localparam int B_ACK    = 13;
  localparam int B_NACK   = 25;
  localparam int B_FRST   = 16;

  localparam logic [31:0] STAT_MASK = (32'd1 << B_BUSERR) | (32'd1 << B_HI) |
    (32'd1 << B_EMPTY) | (32'd1 << B_FULL) | (32'd1 << B_ARB) |
    (32'd1 << B_DONE) | (32'd1 << B_ACK) | (32'd1 << B_NACK);

  logic [DW-1:0] mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] cnt;
  logic [7:0]    hi_thr, lo_thr;
  logic [31:0]   en_q, status_q, set_v, clr_v;
  logic          popped;

  wire wr_ctrl  = reg_wr && reg_addr == A_CTRL;
  wire wr_en    = reg_wr && reg_addr == A_EN;
  wire wr_stat  = reg_wr && reg_addr == A_STAT;
  wire fifo_clr = wr_ctrl && reg_wdata[B_FRST];
  wire full     = cnt == CW'(DEPTH);
  wire empty    = cnt == '0;
  wire do_push  = fifo_push && !full && !fifo_clr;
  wire do_pop   = fifo_pop && !empty && !fifo_clr;

  always_ff @(posedge clk)
    if (do_push) mem[wr_ptr] <= push_byte;

  assign pop_byte = mem[rd_ptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
      popped <= 1'b0;
    end else if (fifo_clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + PW'(1);
      if (do_pop) begin
        rd_ptr <= rd_ptr + PW'(1);
        popped <= 1'b1;
      end
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + CW'(1);
        2'b01:   cnt <= cnt - CW'(1);
        default: cnt <= cnt;
      endcase
    end
  end

  always_comb begin
    set_v           = '0;
    set_v[B_BUSERR] = ev_bus_err;
    set_v[B_ARB]    = ev_arb_lost;
    set_v[B_DONE]   = ev_done;
    set_v[B_ACK]    = ev_addr_ack;
    set_v[B_NACK]   = ev_addr_nack;
    set_v[B_HI]     = (hi_thr != '0) && (32'(cnt) >= 32'(hi_thr));
    set_v[B_EMPTY]  = popped && empty;
    set_v[B_FULL]   = full;
  end

  assign clr_v = wr_stat ? (reg_wdata & STAT_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      en_q     <= '0;
      hi_thr   <= '0;
      lo_thr   <= '0;
    end else begin
      status_q <= (status_q & ~clr_v) | set_v;
      if (wr_en) en_q <= reg_wdata & STAT_MASK;
      if (wr_ctrl) begin
        hi_thr <= reg_wdata[15:8];
        lo_thr <= reg_wdata[7:0];
      end
    end
  end

  assign irq      = |(status_q & en_q);
  assign xfer_err = status_q[B_BUSERR] | status_q[B_ARB] | status_q[B_NACK];

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {16'd0, hi_thr, lo_thr};
      A_LVL:   reg_rdata = 32'(cnt);
      A_EN:    reg_rdata = en_q;
      default: reg_rdata = status_q;
    endcase
  end

  p_level_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) <= DEPTH);

  p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full && fifo_push && !fifo_pop && !fifo_clr |=> full);

  p_event_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_arb_lost |=> status_q[B_ARB]);

  p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((status_q & $past(status_q)) == $past(status_q)));

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ev_bus_err && wr_stat |=> status_q[B_BUSERR]);

  p_mask_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && reg_wdata == '0 |=> !irq);

  p_fifo_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_clr |=> cnt == '0);
endmodule

// File: tb/sim_fifo_irq_ctrl.sv
`timescale 1ns/1ps
module sim_fifo_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic fifo_push = 1'b0, fifo_pop = 1'b0;
  logic [7:0] push_byte = '0, pop_byte;
  logic ev_bus_err = 0, ev_arb_lost = 0, ev_done = 0, ev_addr_ack = 0, ev_addr_nack = 0;
  logic irq, xfer_err;
  int total = 0, fails = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  fifo_irq_ctrl u0 (.clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
    .fifo_push, .push_byte, .fifo_pop, .pop_byte, .ev_bus_err, .ev_arb_lost,
    .ev_done, .ev_addr_ack, .ev_addr_nack, .irq, .xfer_err);

  // kind: 0 write, 1 read and compare, 2 event pulse (mask bit0 bus,1 arb,2 done,3 ack,4 nack),
  // 3 compare irq, 4 compare xfer_err; then tag, address, data, expected
  localparam int NV = 25;
  localparam logic [75:0] VEC [NV] = '{
    {3'd1, 7'd1, 2'd3, 32'h0, 32'h0},          // R1 status
    {3'd1, 7'd1, 2'd2, 32'h0, 32'h0},          // R1 enable
    {3'd1, 7'd1, 2'd1, 32'h0, 32'h0},          // R1 level
    {3'd1, 7'd1, 2'd0, 32'h0, 32'h0},          // R1 thresholds
    {3'd3, 7'd1, 2'd0, 32'h0, 32'h0},          // R1 irq
    {3'd2, 7'd6, 2'd0, 32'h01, 32'h0},
    {3'd1, 7'd6, 2'd3, 32'h0, 32'h1},          // R6 bus error
    {3'd2, 7'd6, 2'd0, 32'h12, 32'h0},
    {3'd1, 7'd7, 2'd3, 32'h0, 32'h02000801},   // R7 R6
    {3'd0, 7'd8, 2'd3, 32'h800, 32'h0},
    {3'd1, 7'd8, 2'd3, 32'h0, 32'h02000001},   // R8 clear one bit
    {3'd0, 7'd9, 2'd2, 32'h1000, 32'h0},
    {3'd3, 7'd9, 2'd0, 32'h0, 32'h0},          // R9 masked
    {3'd2, 7'd9, 2'd0, 32'h04, 32'h0},
    {3'd3, 7'd9, 2'd0, 32'h0, 32'h1},          // R9 enabled
    {3'd0, 7'd9, 2'd2, 32'h0, 32'h0},
    {3'd3, 7'd9, 2'd0, 32'h0, 32'h0},          // R9 silenced
    {3'd4, 7'd11, 2'd0, 32'h0, 32'h1},         // R11
    {3'd0, 7'd8, 2'd3, 32'hFFFFFFFF, 32'h0},
    {3'd1, 7'd8, 2'd3, 32'h0, 32'h0},          // R8 clear all
    {3'd4, 7'd11, 2'd0, 32'h0, 32'h0},         // R11
    {3'd2, 7'd6, 2'd0, 32'h08, 32'h0},
    {3'd1, 7'd6, 2'd3, 32'h0, 32'h00002000},   // R6 address ack
    {3'd0, 7'd4, 2'd0, 32'h0305, 32'h0},
    {3'd1, 7'd4, 2'd0, 32'h0, 32'h0305}        // R4 thresholds
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic push(input logic [7:0] b);
    fifo_push = 1'b1; push_byte = b;
    tick();
    fifo_push = 1'b0;
  endtask

  task automatic pop(output logic [7:0] b);
    b = pop_byte;
    fifo_pop = 1'b1;
    tick();
    fifo_pop = 1'b0;
  endtask

  task automatic pulse(input logic [4:0] m);
    {ev_addr_nack, ev_addr_ack, ev_done, ev_arb_lost, ev_bus_err} = m;
    tick();
    {ev_addr_nack, ev_addr_ack, ev_done, ev_arb_lost, ev_bus_err} = '0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    logic [31:0] v, s0;
    logic [7:0] b;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NV; i++) begin
      logic [2:0] k;
      logic [6:0] tg;
      logic [1:0] a;
      logic [31:0] d, e;
      string tag;
      {k, tg, a, d, e} = VEC[i];
      tag = $sformatf("R%0d vector %0d", tg, i);
      case (k)
        3'd0: wr(a, d);
        3'd1: begin rd(a, v); check(tag, v, e); end
        3'd2: pulse(d[4:0]);
        3'd3: check(tag, {31'd0, irq}, e);
        default: check(tag, {31'd0, xfer_err}, e);
      endcase
    end

    // R4 and R5: below threshold, no pop yet
    wr(2'd3, 32'hFFFFFFFF);
    push(8'hA0); push(8'hA1);
    tick();
    rd(2'd3, v);
    check("R4 below threshold", v & 32'h4, 32'h0);
    check("R5 no pop yet", v & 32'h8, 32'h0);
    push(8'hA2); push(8'hA3); push(8'hA4);
    rd(2'd1, v);
    check("R2 level", v, 32'd5);
    tick();
    rd(2'd3, v);
    check("R4 at threshold", v & 32'h4, 32'h4);
    for (int i = 0; i < 5; i++) begin
      pop(b);
      check("R2 order", {24'd0, b}, 32'hA0 + i);
    end
    tick();
    rd(2'd3, v);
    check("R5 empty after pop", v & 32'h8, 32'h8);
    check("R7 threshold sticky", v & 32'h4, 32'h4);

    // R8: clear collides with the live empty condition
    wr(2'd3, 32'h8);
    rd(2'd3, v);
    check("R8 set wins", v & 32'h8, 32'h8);
    pop(b);
    rd(2'd1, v);
    check("R3 pop while empty", v, 32'd0);

    // R4: zero threshold never fires
    wr(2'd0, 32'h0);
    wr(2'd3, 32'h4);
    push(8'h11); push(8'h12); push(8'h13); push(8'h14);
    tick();
    rd(2'd3, v);
    check("R4 zero threshold", v & 32'h4, 32'h0);

    // R3: overfill
    wr(2'd0, 32'h10000);
    for (int i = 0; i < 130; i++) push(8'(i));
    rd(2'd1, v);
    check("R3 level at full", v, 32'h80);
    tick();
    rd(2'd3, v);
    check("R3 full bit", v & 32'h10, 32'h10);
    pop(b);
    check("R3 head kept", {24'd0, b}, 32'h0);

    // R10: FIFO reset keeps status
    pulse(5'h01);
    rd(2'd3, s0);
    wr(2'd0, 32'h10200);
    rd(2'd1, v);
    check("R10 level cleared", v, 32'd0);
    rd(2'd3, v);
    check("R10 status kept", v & ~32'h8, s0 & ~32'h8);
    rd(2'd0, v);
    check("R10 thresholds loaded", v, 32'h0200);
    push(8'h5A);
    pop(b);
    check("R10 pointers reset", {24'd0, b}, 32'h5A);

    finished = 1;
    summary();
  end

  initial begin
    #(20 * 100000);
    if (!finished) begin
      total++;
      fails++;
      $display("FAIL watchdog actual=hung expected=done");
      summary();
    end
  end
endmodule